// File: doc/BRIEF.md
# Cross-Domain Trigger Forwarding Network

This block joins several capture units, each clocked in its own domain, into one trigger network. Every unit compares its sampled data word against a programmed compare value under a care mask. The first hit after arming becomes that unit's local trigger, which is offered to every unit in the network, the unit itself included. Each unit then forms its final trigger from the sources picked by its own select mask. In any-of mode one selected source is enough. In all-of mode every selected source must have fired since the unit was last armed.

How a trigger travels between two units is fixed at build time from a clock-group number given to each unit. Units in the same group share one clock, and the trigger passes as a one-cycle pulse that the receiver uses in the same cycle. Units in different groups may run on unrelated clocks. There the source holds a level until it is rearmed, and the receiver passes that level through a two-flop synchroniser and a rising-edge detector before using it. A unit disarms itself when its final trigger fires and stays idle until software pulses its arm input again.

Top module: `xtrig_net`

## Requirements
- R1: A unit's local condition is true when `((data ^ cmp_val) & care_mask) == 0` over that unit's DATA_W-bit slice. Bits whose care bit is 0 are ignored, so an all-zero care mask matches any word.
- R2: After reset every unit is disarmed and all `trig_out` bits are 0. A disarmed unit produces no local trigger and no final trigger, whatever its data.
- R3: A one-cycle pulse on `arm[i]` arms unit i from the next edge of its clock. It clears the unit's record of fired sources and drops the unit's forwarded level.
- R4: `trig_out[i]` is high for exactly one cycle, in the cycle its condition is first met while armed. The unit is then disarmed until it is rearmed.
- R5: With `mode_and[i]=0` (any-of), unit i fires when any source selected in `src_sel[i*N_UNITS +: N_UNITS]` (bit j selects unit j) delivers a trigger event.
- R6: With `mode_and[i]=1` (all-of), unit i fires only once every selected source has delivered an event since arming. Events that arrive earlier are remembered as sticky bits.
- R7: A unit whose select mask is all zero never fires, in either mode.
- R8: On a link between units of the same clock group, the receiver's `trig_out` rises in the same cycle as the source's first local hit, with no added cycle.
- R9: On a link between different clock groups, the receiver's `trig_out` rises within three receiver clock edges after the source edge that registers the hit. Each synchronised event lasts one receiver cycle.
- R10: Only the first hit after arming is forwarded. The source holds its forwarded level until it is rearmed. A receiver records no event while it is disarmed, so rearming a receiver while the source level is still held does not make it fire.
- R11: Every unit can receive triggers from every other unit, on both same-group and cross-group links.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | N_UNITS | Clock of each unit; units in the same clock group must share one clock |
| rst_n | input | N_UNITS | Active-low asynchronous reset of each unit |
| arm | input | N_UNITS | One-cycle arm/rearm pulse of each unit, in its own domain |
| mode_and | input | N_UNITS | Combine mode per unit: 0 any-of, 1 all-of |
| src_sel | input | N_UNITS*N_UNITS | Select mask per unit; slice i, bit j selects source unit j |
| data | input | N_UNITS*DATA_W | Sampled data word of each unit |
| cmp_val | input | N_UNITS*DATA_W | Compare value of each unit |
| care_mask | input | N_UNITS*DATA_W | Care mask of each unit; 1 means the bit is compared |
| trig_out | output | N_UNITS | Final trigger pulse of each unit |

## Verification
The final trigger is combinational from registered state and the unit's own inputs. So a local or same-group result is due in the cycle the stimulus is applied, and the bench samples it one time step after driving at the falling edge. A cross-group result is due at the second receiver edge after the source edge. The bench waits for that source edge, counts receiver rising edges while sampling at each falling edge, and accepts a count of two or three. Disarm and ignore checks sample the next falling edge and several after it, which covers the time the synchroniser needs to settle.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  localparam int unsigned WORD_MAX = 64;
  localparam int unsigned SRC_MAX  = 32;

  typedef enum logic {
    COMB_ANY = 1'b0,
    COMB_ALL = 1'b1
  } comb_mode_e;

  // Masked equality: only cared-for bits take part in the compare.
  function automatic logic word_hit(input logic [WORD_MAX-1:0] data,
                                    input logic [WORD_MAX-1:0] cmp,
                                    input logic [WORD_MAX-1:0] care);
    return ((data ^ cmp) & care) == '0;
  endfunction

  // Combine fired sources under a select mask; an empty mask never fires.
  function automatic logic comb_result(input logic [SRC_MAX-1:0] sel,
                                       input logic [SRC_MAX-1:0] got,
                                       input comb_mode_e          mode);
    logic res;
    if (sel == '0)              res = 1'b0;
    else if (mode == COMB_ALL)  res = ((got & sel) == sel);
    else                        res = |(got & sel);
    return res;
  endfunction

endpackage

// File: rtl/xtrig_cond.sv
module xtrig_cond
  import xtrig_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              armed,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] cmp,
  input  logic [DATA_W-1:0] care,
  output logic              first_pulse,
  output logic              fwd_level
);

  logic match;
  logic hit;
  logic fwd_q;

  assign match       = word_hit(WORD_MAX'(data), WORD_MAX'(cmp), WORD_MAX'(care));
  assign hit         = armed & match;
  assign first_pulse = hit & ~fwd_q;
  assign fwd_level   = fwd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fwd_q <= 1'b0;
    else if (arm)   fwd_q <= 1'b0;
    else if (hit)   fwd_q <= 1'b1;
  end

  // Forwarded level stays up until a rearm.
  p_level_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_q && !arm |=> fwd_q);

  // A new forwarded level only comes from an armed unit.
  p_rise_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_q) |-> $past(armed));

endmodule

// File: rtl/xtrig_sync.sv
module xtrig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic evt
);

  // stage[0], stage[1]: synchroniser; stage[2]: history for edge detect
  logic [2:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[1:0], level_in};
  end

  assign evt = stage[1] & ~stage[2];

  p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/xtrig_comb.sv
module xtrig_comb
  import xtrig_pkg::*;
#(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             mode,
  input  logic [N_SRC-1:0] sel,
  input  logic [N_SRC-1:0] evt,
  output logic             trig,
  output logic             armed
);

  logic             armed_q;
  logic [N_SRC-1:0] seen_q;
  logic [N_SRC-1:0] got;

  assign got   = seen_q | evt;
  assign trig  = armed_q & comb_result(SRC_MAX'(sel), SRC_MAX'(got), comb_mode_e'(mode));
  assign armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      seen_q  <= '0;
    end else if (armed_q) begin
      seen_q <= got;
      if (trig) armed_q <= 1'b0;
    end
  end

  p_arm_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed_q && seen_q == '0);

  p_disarm_after_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !arm |=> !armed_q);

  p_seen_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !arm |=> $stable(seen_q));

  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> sel != '0);

endmodule

// File: rtl/xtrig_net.sv
module xtrig_net #(
  parameter int unsigned N_UNITS = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned GROUP_W = 4,
  parameter logic [N_UNITS*GROUP_W-1:0] CLK_GROUP = 'h100
) (
  input  logic [N_UNITS-1:0]         clk,
  input  logic [N_UNITS-1:0]         rst_n,
  input  logic [N_UNITS-1:0]         arm,
  input  logic [N_UNITS-1:0]         mode_and,
  input  logic [N_UNITS*N_UNITS-1:0] src_sel,
  input  logic [N_UNITS*DATA_W-1:0]  data,
  input  logic [N_UNITS*DATA_W-1:0]  cmp_val,
  input  logic [N_UNITS*DATA_W-1:0]  care_mask,
  output logic [N_UNITS-1:0]         trig_out
);

  localparam int unsigned N_LINKS = N_UNITS * N_UNITS;

  logic [N_UNITS-1:0] armed;
  logic [N_UNITS-1:0] first_pulse;
  logic [N_UNITS-1:0] fwd_level;
  logic [N_LINKS-1:0] rx_evt;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    xtrig_cond #(.DATA_W(DATA_W)) u_cond (
      .clk         (clk[i]),
      .rst_n       (rst_n[i]),
      .arm         (arm[i]),
      .armed       (armed[i]),
      .data        (data[i*DATA_W +: DATA_W]),
      .cmp         (cmp_val[i*DATA_W +: DATA_W]),
      .care        (care_mask[i*DATA_W +: DATA_W]),
      .first_pulse (first_pulse[i]),
      .fwd_level   (fwd_level[i])
    );

    xtrig_comb #(.N_SRC(N_UNITS)) u_comb (
      .clk   (clk[i]),
      .rst_n (rst_n[i]),
      .arm   (arm[i]),
      .mode  (mode_and[i]),
      .sel   (src_sel[i*N_UNITS +: N_UNITS]),
      .evt   (rx_evt[i*N_UNITS +: N_UNITS]),
      .trig  (trig_out[i]),
      .armed (armed[i])
    );

    for (genvar j = 0; j < N_UNITS; j++) begin : g_src
      localparam bit SAME_CLK =
        (CLK_GROUP[i*GROUP_W +: GROUP_W] == CLK_GROUP[j*GROUP_W +: GROUP_W]);
      if (SAME_CLK) begin : g_pulse
        // Same clock: the first-hit pulse is used in the cycle it occurs.
        assign rx_evt[i*N_UNITS + j] = first_pulse[j];
      end else begin : g_level
        xtrig_sync u_sync (
          .clk      (clk[i]),
          .rst_n    (rst_n[i]),
          .level_in (fwd_level[j]),
          .evt      (rx_evt[i*N_UNITS + j])
        );
      end
    end
  end

endmodule

// File: tb/xtrig_net_bench.sv
module xtrig_net_bench;

  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam logic [DW-1:0] CMPV = 8'hA5;
  localparam logic [DW-1:0] IDLE = 8'h00;

  logic clk_a, clk_b;
  logic [N-1:0] rst_n;
  logic [N-1:0] arm;
  logic [N-1:0] mode_and;
  logic [DW-1:0] d [N];
  logic [DW-1:0] cmp [N];
  logic [DW-1:0] cr [N];
  logic [N-1:0] sel [N];
  logic [N-1:0] trig_out;

  int n_chk  = 0;
  int n_fail = 0;

  xtrig_net #(.N_UNITS(N), .DATA_W(DW), .GROUP_W(4), .CLK_GROUP(12'h100)) u_xtrig_net (
    .clk       ({clk_b, clk_a, clk_a}),
    .rst_n     (rst_n),
    .arm       (arm),
    .mode_and  (mode_and),
    .src_sel   ({sel[2], sel[1], sel[0]}),
    .data      ({d[2], d[1], d[0]}),
    .cmp_val   ({cmp[2], cmp[1], cmp[0]}),
    .care_mask ({cr[2], cr[1], cr[0]}),
    .trig_out  (trig_out)
  );

  initial begin
    clk_a = 1'b0;
    forever #(CLK_PERIOD/2) clk_a = ~clk_a;
  end

  initial begin
    clk_b = 1'b0;
    #3;
    forever #(CLK_B_PERIOD/2) clk_b = ~clk_b;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic neg(input int u);
    if (u == 2) @(negedge clk_b);
    else        @(negedge clk_a);
  endtask

  task automatic do_arm(input int u);
    neg(u); arm[u] = 1'b1;
    neg(u); arm[u] = 1'b0;
  endtask

  task automatic fire(input int u);
    neg(u); d[u] = CMPV;
    neg(u); d[u] = IDLE;
  endtask

  // Hit on the unit's input, return right after the edge that registers it.
  task automatic fire_edge(input int u);
    neg(u); d[u] = CMPV;
    if (u == 2) @(posedge clk_b);
    else        @(posedge clk_a);
    #1 d[u] = IDLE;
  endtask

  task automatic expect_quiet(input int u, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      neg(u);
      check(trig_out[u] == 1'b0, req, trig_out[u], 0);
    end
  endtask

  // Count receiver rising edges until its trigger is seen; 99 if never.
  task automatic count_edges(input int u, output int cnt);
    cnt = 99;
    for (int k = 1; k <= 8; k++) begin
      if (u == 2) begin @(posedge clk_b); @(negedge clk_b); end
      else        begin @(posedge clk_a); @(negedge clk_a); end
      if (trig_out[u]) begin cnt = k; break; end
    end
  endtask

  task automatic wait_fire(input int u, input int n, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      neg(u);
      if (trig_out[u]) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    int  cnt;
    bit  seen;
    logic [DW-1:0] care_v;
    rst_n = '0; arm = '0; mode_and = '0;
    for (int u = 0; u < N; u++) begin
      d[u] = IDLE; cmp[u] = CMPV; cr[u] = 8'hFF; sel[u] = '0;
    end
    repeat (3) @(negedge clk_b);
    rst_n = '1;

    // R2: reset state, and disarmed units ignore matching data
    @(negedge clk_a); #1;
    check(trig_out == '0, "R2 reset", trig_out, 0);
    sel[0] = 3'b001; sel[1] = 3'b010; sel[2] = 3'b100;
    d[0] = CMPV; d[1] = CMPV; d[2] = CMPV;
    expect_quiet(0, 3, "R2 disarmed");
    expect_quiet(2, 2, "R2 disarmed");
    d[0] = IDLE; d[1] = IDLE; d[2] = IDLE;
    sel[1] = '0; sel[2] = '0;

    // R1: sweep all data words under several care masks (self-select, any-of)
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: care_v = 8'hFF;
        1: care_v = 8'h0F;
        2: care_v = 8'h00;
        default: care_v = 8'h5A;
      endcase
      cr[0] = care_v;
      for (int v = 0; v < 256; v++) begin
        do_arm(0);
        d[0] = DW'(v);
        #1;
        check(trig_out[0] == ((((DW'(v)) ^ CMPV) & care_v) == 0), "R1 match",
              trig_out[0], int'((((DW'(v)) ^ CMPV) & care_v) == 0));
        neg(0); d[0] = IDLE;
      end
    end
    cr[0] = 8'hFF;

    // R2: after firing the unit is disarmed and ignores further matches
    do_arm(0);
    fire(0);
    d[0] = CMPV;
    expect_quiet(0, 3, "R2 after fire");
    d[0] = IDLE;

    // R8: same-group link 0->1, result in the same cycle; R4 one-cycle pulse
    sel[0] = '0; sel[1] = 3'b001;
    do_arm(0); do_arm(1);
    neg(0); d[0] = CMPV; #1;
    check(trig_out[1] == 1'b1, "R8 same-cycle", trig_out[1], 1);
    check(trig_out[0] == 1'b0, "R7 unit0 empty mask", trig_out[0], 0);
    neg(0); d[0] = IDLE; #1;
    check(trig_out[1] == 1'b0, "R4 pulse width", trig_out[1], 0);

    // R10: receiver rearmed while source level held does not fire again
    do_arm(1);
    expect_quiet(1, 4, "R10 held level");
    fire(0);
    expect_quiet(1, 2, "R10 first hit only");

    // R9: cross-group link 0->2
    sel[2] = 3'b001;
    sel[1] = '0;
    do_arm(0);
    repeat (6) @(negedge clk_b);
    do_arm(2);
    fire_edge(0);
    count_edges(2, cnt);
    check(cnt >= 2 && cnt <= 3, "R9 latency", cnt, 2);
    neg(2); #1;
    check(trig_out[2] == 1'b0, "R4 cross pulse width", trig_out[2], 0);
    do_arm(2);
    expect_quiet(2, 8, "R10 cross held level");

    // R11: cross-group link 2->0
    sel[0] = 3'b100; sel[2] = '0;
    do_arm(0); do_arm(2);
    fire_edge(2);
    count_edges(0, cnt);
    check(cnt >= 2 && cnt <= 3, "R11 reverse link", cnt, 2);

    // R6: all-of on unit1 over sources 0 and 2
    sel[0] = '0; sel[1] = 3'b101; mode_and[1] = 1'b1;
    do_arm(0); do_arm(2);
    repeat (6) @(negedge clk_a);
    do_arm(1);
    fire(0);
    expect_quiet(1, 8, "R6 one of two");
    fire_edge(2);
    wait_fire(1, 6, seen);
    check(seen, "R6 all fired", seen, 1);
    neg(1); #1;
    check(trig_out[1] == 1'b0, "R4 disarm", trig_out[1], 0);

    // R3: rearm clears remembered sources
    do_arm(0); do_arm(2);
    repeat (6) @(negedge clk_a);
    do_arm(1);
    fire(0);
    repeat (2) @(negedge clk_a);
    do_arm(1);
    fire_edge(2);
    expect_quiet(1, 8, "R3 sticky cleared");

    // R5: any-of on unit1, only source 2 fires
    mode_and[1] = 1'b0;
    do_arm(2);
    repeat (6) @(negedge clk_a);
    do_arm(1);
    fire_edge(2);
    wait_fire(1, 6, seen);
    check(seen, "R5 any-of", seen, 1);

    // R10: events reaching a disarmed receiver are not remembered
    sel[1] = 3'b010;
    do_arm(1);
    fire(1);
    sel[1] = 3'b001;
    do_arm(0);
    fire(0);
    do_arm(1);
    expect_quiet(1, 4, "R10 disarmed receiver");

    // R7: empty mask never fires, in both modes
    sel[1] = '0;
    for (int m = 0; m < 2; m++) begin
      mode_and[1] = 1'(m);
      do_arm(0); do_arm(1);
      neg(1); d[0] = CMPV; d[1] = CMPV; #1;
      check(trig_out[1] == 1'b0, "R7 empty mask", trig_out[1], 0);
      neg(1); d[0] = IDLE; d[1] = IDLE;
      expect_quiet(1, 2, "R7 empty mask");
    end

    summary();
    $finish;
  end

endmodule